// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Chain

This block holds a row of interrupt nodes, one per device, joined in series on three control lines: a shared request line, an acknowledge line and a service-end line. A device pulses its own request input and its node latches the request as pending. The node then drives the shared, wired-OR request line that goes to the processor. The processor answers with a one-cycle acknowledge pulse. That pulse enters node 0 and travels from node to node. The first node that is holding a request claims the pulse and keeps it from reaching the nodes behind it. That node becomes granted, and its index is presented as the device identifier. The service-end pulse travels down the same chain. The first granted node it reaches absorbs it and returns to idle.

Priority comes only from position: a lower index sits nearer the processor and wins. Each node keeps nothing but its own small state, so the chain grows one node per device. A granted node blocks acknowledges for everything behind it. A node ahead of it can still be granted, which nests its service inside the current one. The next service-end then closes the innermost service first.

Top module: `irq_daisy_chain`

## Requirements
- R1: After reset no node is pending or granted: `irq_out`, `grant` and `id_valid` are 0, and both tails follow their inputs.
- R2: A high on `dev_req[i]` for one clock makes node i pending from the next clock. `irq_out` is 1 while any node is pending and not yet granted.
- R3: `ack_in` reaches `ack_tail` in the same cycle when no node is pending or granted.
- R4: The nearest pending node claims an `ack_in` pulse: its bit of `grant` is set from the next clock and `ack_tail` stays 0. Nodes behind it gain nothing from that pulse.
- R5: While any `grant` bit is set, `id_valid` is 1 and `id_out` is the index of the lowest set bit; otherwise `id_valid` is 0.
- R6: `done_in` passes through nodes that are not granted. The nearest granted node absorbs it (`done_tail` is 0 in that cycle) and clears its grant bit at the next clock.
- R7: A pending node that is not granted keeps its request through other nodes' acknowledge and service-end pulses, and is granted by a later acknowledge.
- R8: A request strobe on a node that is granted is remembered. When that node's service ends, it becomes pending again.
- R9: An acknowledge that reaches a granted node stops there and grants nothing new. A second strobe on a node that is already pending adds no second service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | NODES | Request strobes, one per device; bit 0 is nearest the processor |
| ack_in | input | 1 | Acknowledge pulse (one cycle) entering node 0 |
| done_in | input | 1 | Service-end pulse (one cycle) entering node 0 |
| irq_out | output | 1 | Wired-OR of the pending requests of all nodes |
| ack_tail | output | 1 | Acknowledge leaving the last node |
| done_tail | output | 1 | Service-end leaving the last node |
| grant | output | NODES | Granted flag of each node |
| id_out | output | ID_W | Index of the nearest granted node |
| id_valid | output | 1 | At least one node is granted |

## Verification
The bench builds the chain with NODES = 5, so the identifier is three bits wide and there are nodes ahead of, between and behind the active ones. At that size one run can nest a service on node 0 inside a service on node 2 while node 4 waits. The same run covers a remembered re-request on the last node and a service-end that passes a pending node. A scoreboard records the identifier expected for each new grant and compares it with the identifier the chain presents.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

   typedef enum logic [1:0] {
      ND_IDLE = 2'b00,
      ND_PEND = 2'b01,
      ND_SERV = 2'b10
   } node_st_e;

   function automatic int unsigned id_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_chain_node.sv
module irq_chain_node
   import irq_chain_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_stb,
   input  logic ack_up,
   input  logic done_up,
   output logic ack_dn,
   output logic done_dn,
   output logic irq_o,
   output logic serv_o
);

   node_st_e st_q, st_d;
   logic     rearm_q, rearm_d;

   always_comb begin
      st_d    = st_q;
      rearm_d = rearm_q;
      unique case (st_q)
         ND_IDLE: if (req_stb) st_d = ND_PEND;
         ND_PEND: if (ack_up)  st_d = ND_SERV;
         ND_SERV: begin
            if (done_up) begin
               st_d    = (rearm_q || req_stb) ? ND_PEND : ND_IDLE;
               rearm_d = 1'b0;
            end else if (req_stb) begin
               rearm_d = 1'b1;
            end
         end
         default: st_d = ND_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ND_IDLE;
         rearm_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         rearm_q <= rearm_d;
      end
   end

   // an idle node is transparent to acknowledge; any claim opens the chain
   assign ack_dn  = ack_up & (st_q == ND_IDLE);
   // only a node in service consumes the service-end pulse
   assign done_dn = done_up & (st_q != ND_SERV);
   assign irq_o   = (st_q == ND_PEND);
   assign serv_o  = (st_q == ND_SERV);

endmodule

// File: rtl/irq_id_pick.sv
module irq_id_pick #(
   parameter int unsigned NODES = 8,
   parameter int unsigned ID_W  = 3
) (
   input  logic [NODES-1:0] serv,
   output logic [ID_W-1:0]  id,
   output logic             valid
);

   generate
      if (NODES == 1) begin : g_single
         assign id    = '0;
         assign valid = serv[0];
      end else begin : g_multi
         always_comb begin
            id = '0;
            for (int i = NODES - 1; i >= 0; i--) begin
               if (serv[i]) id = ID_W'(i);
            end
         end
         assign valid = |serv;
      end
   endgenerate

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
   parameter  int unsigned NODES = 8,
   localparam int unsigned ID_W  = irq_chain_pkg::id_width(NODES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NODES-1:0] dev_req,
   input  logic             ack_in,
   input  logic             done_in,
   output logic             irq_out,
   output logic             ack_tail,
   output logic             done_tail,
   output logic [NODES-1:0] grant,
   output logic [ID_W-1:0]  id_out,
   output logic             id_valid
);

   generate
      if (NODES < 1 || NODES > 65536) begin : g_bad_nodes
         $error("irq_daisy_chain: NODES must lie in 1..65536");
      end
   endgenerate

   logic [NODES:0]   ack_c;
   logic [NODES:0]   done_c;
   logic [NODES-1:0] pend_v;

   assign ack_c[0]  = ack_in;
   assign done_c[0] = done_in;

   generate
      for (genvar g = 0; g < NODES; g++) begin : g_node
         irq_chain_node u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_stb (dev_req[g]),
            .ack_up  (ack_c[g]),
            .done_up (done_c[g]),
            .ack_dn  (ack_c[g+1]),
            .done_dn (done_c[g+1]),
            .irq_o   (pend_v[g]),
            .serv_o  (grant[g])
         );
      end
   endgenerate

   irq_id_pick #(.NODES(NODES), .ID_W(ID_W)) u_pick (
      .serv  (grant),
      .id    (id_out),
      .valid (id_valid)
   );

   assign irq_out   = |pend_v;
   assign ack_tail  = ack_c[NODES];
   assign done_tail = done_c[NODES];

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
   parameter int unsigned NODES = 8,
   parameter int unsigned ID_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack_in,
   input logic             done_in,
   input logic             irq_out,
   input logic             ack_tail,
   input logic             done_tail,
   input logic [NODES-1:0] grant,
   input logic [ID_W-1:0]  id_out,
   input logic             id_valid
);

   AST_GRANT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~$past(grant)) != '0) |-> $past(ack_in)); // R4

   AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant & ~$past(grant)) <= 1); // R4

   AST_ACK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in && irq_out) |-> !ack_tail); // R4

   AST_RELEASE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((~grant & $past(grant)) != '0) |-> $past(done_in)); // R6

   AST_DONE_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
      (done_in && grant != '0) |-> !done_tail); // R6

   AST_ID_NEAREST: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |-> (((grant >> id_out) & NODES'(1)) != '0) &&
                   ((grant & ((NODES'(1) << id_out) - NODES'(1))) == '0)); // R5

   AST_NO_ID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0) |-> !id_valid); // R5

endmodule

bind irq_daisy_chain irq_chain_chk #(.NODES(NODES), .ID_W(ID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack_in    (ack_in),
   .done_in   (done_in),
   .irq_out   (irq_out),
   .ack_tail  (ack_tail),
   .done_tail (done_tail),
   .grant     (grant),
   .id_out    (id_out),
   .id_valid  (id_valid)
);

// File: tb/irq_daisy_chain_test.sv
module irq_daisy_chain_test;

   localparam int N  = 5;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  dev_req = '0;
   logic          ack_in = 1'b0;
   logic          done_in = 1'b0;
   logic          irq_out, ack_tail, done_tail, id_valid;
   logic [N-1:0]  grant;
   logic [IW-1:0] id_out;

   int n_cmp = 0;
   int n_bad = 0;
   int exp_q[$];
   logic [N-1:0] prev_grant = '0;
   bit finished = 0;

   irq_daisy_chain #(.NODES(N)) uut (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .ack_in(ack_in),
      .done_in(done_in), .irq_out(irq_out), .ack_tail(ack_tail),
      .done_tail(done_tail), .grant(grant), .id_out(id_out), .id_valid(id_valid)
   );

   always #4 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every newly set grant bit pops one expected identifier
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if ((grant & ~prev_grant) != '0) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL R5 scoreboard: actual id %0d expected none", id_out);
            end else begin
               int e;
               e = exp_q.pop_front();
               if (int'(id_out) != e || !id_valid) begin
                  n_bad++;
                  $display("FAIL R5 scoreboard: actual id %0d expected %0d", id_out, e);
               end
            end
         end
         prev_grant = grant;
      end
   end

   // all tasks start and end just after a falling edge
   task automatic strobe(input logic [N-1:0] m);
      dev_req = m;
      @(negedge clk);
      dev_req = '0;
   endtask

   task automatic ack_pulse(input string tag, input logic exp_tail);
      ack_in = 1'b1;
      #1 chk({tag, " ack_tail"}, 32'(ack_tail), 32'(exp_tail));
      @(negedge clk);
      ack_in = 1'b0;
   endtask

   task automatic done_pulse(input string tag, input logic exp_tail);
      done_in = 1'b1;
      #1 chk({tag, " done_tail"}, 32'(done_tail), 32'(exp_tail));
      @(negedge clk);
      done_in = 1'b0;
   endtask

   task automatic state_is(input string tag, input logic [N-1:0] g, input logic irq);
      chk({tag, " grant"}, 32'(grant), 32'(g));
      chk({tag, " irq_out"}, 32'(irq_out), 32'(irq));
      chk({tag, " id_valid"}, 32'(id_valid), 32'(g != '0));
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state and transparent tails
      state_is("R1", '0, 1'b0);
      ack_in = 1'b1;
      #1 chk("R3 idle ack pass", 32'(ack_tail), 32'd1);
      ack_in = 1'b0;
      done_in = 1'b1;
      #1 chk("R1 idle done pass", 32'(done_tail), 32'd1);
      done_in = 1'b0;
      @(negedge clk);

      // R2 single request on node 2, then R4 claim
      strobe(5'b00100);
      state_is("R2 pending", '0, 1'b1);
      exp_q.push_back(2);
      ack_pulse("R4 claim", 1'b0);
      state_is("R4 granted", 5'b00100, 1'b0);
      chk("R5 id", 32'(id_out), 32'd2);

      // R9 ack at a granted node grants nothing
      ack_pulse("R9 blocked", 1'b0);
      state_is("R9 unchanged", 5'b00100, 1'b0);

      // R7 nodes 0 and 4 request while node 2 is served; node 0 nests
      strobe(5'b10001);
      state_is("R7 waiting", 5'b00100, 1'b1);
      exp_q.push_back(0);
      ack_pulse("R4 nest", 1'b0);
      state_is("R4 nested", 5'b00101, 1'b1);
      chk("R5 nearest id", 32'(id_out), 32'd0);

      // R6 innermost service ends first
      done_pulse("R6 absorb", 1'b0);
      state_is("R6 inner end", 5'b00100, 1'b1);
      chk("R5 id back", 32'(id_out), 32'd2);
      done_pulse("R6 absorb2", 1'b0);
      state_is("R7 node4 held", '0, 1'b1);

      exp_q.push_back(4);
      ack_pulse("R7 late grant", 1'b0);
      state_is("R7 node4 granted", 5'b10000, 1'b0);
      chk("R5 id4", 32'(id_out), 32'd4);

      // R8 re-request while own service runs
      strobe(5'b10000);
      state_is("R8 remembered", 5'b10000, 1'b0);
      done_pulse("R8 end", 1'b0);
      state_is("R8 pending again", '0, 1'b1);
      exp_q.push_back(4);
      ack_pulse("R8 regrant", 1'b0);
      state_is("R8 served again", 5'b10000, 1'b0);
      done_pulse("R8 end2", 1'b0);
      state_is("R8 idle", '0, 1'b0);

      // R9 double strobe gives a single service
      strobe(5'b00010);
      strobe(5'b00010);
      exp_q.push_back(1);
      ack_pulse("R9 single", 1'b0);
      state_is("R9 granted", 5'b00010, 1'b0);
      done_pulse("R9 end", 1'b0);
      state_is("R9 no second", '0, 1'b0);

      // R6 service-end passes a pending node untouched
      strobe(5'b01000);
      done_pulse("R6 passes pending", 1'b1);
      state_is("R7 still pending", '0, 1'b1);
      exp_q.push_back(3);
      ack_pulse("R4 node3", 1'b0);
      state_is("R4 node3 granted", 5'b01000, 1'b0);
      done_pulse("R6 node3 end", 1'b0);
      state_is("R6 all idle", '0, 1'b0);

      @(negedge clk);
      chk("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
      finished = 1;
      summary();
   end

endmodule